// File: doc/BRIEF.md
# Dual-Port Atomic Word Memory

A small register-based memory that two bus managers reach through pipelined ports, each with address, direction, transfer size, write data and byte strobes. Storage is organised as aligned 32-bit words, and each word is the indivisible unit of update and observation. A write changes every byte it enables on the same clock edge. A read always returns a complete 32-bit word, so no port can observe a word with only some of another port's bytes applied.

Every transfer has an address phase followed by a data phase. Write data and strobes arrive in the data phase, and the write is merged into the stored word when that phase completes. If both ports are in a data phase on the same word and at least one of them writes, a small arbiter lets one finish and holds the other for exactly one cycle. The held port then finishes against the updated contents. A four-beat incrementing burst is a run of single beats, and each beat is arbitrated on its own, so the other port may finish a transfer between two beats.

Top module: `atom_word_mem`

## Requirements
- R1: After reset both ready outputs are high and every word reads as zero.
- R2: A completing write changes exactly the byte lanes enabled by both the size-derived lane mask and the strobes, all on one clock edge. Strobe 4'b1001 changes bytes 0 and 3 together and leaves bytes 1 and 2 as they were.
- R3: Size 3'b000 enables only the lane given by address bits [1:0]. Size 3'b001 enables lanes {1,0} when address bit 1 is 0 and lanes {3,2} when it is 1. Size 3'b010, and any other code, enables all four lanes.
- R4: A read of any size returns the whole 32-bit word, byte reads included.
- R5: An address phase is accepted on an edge where that port's ready is high and its request is high. Its data phase occupies the next cycle. A read returns the word stored at the start of the completing cycle, and write data and strobes are sampled on the completing edge.
- R6: When both data phases address one word, at least one is a write and neither port waited in the previous cycle, port 0 completes and port 1 has ready low for exactly one cycle. Port 1 then completes against the updated contents.
- R7: A port that was held in the previous cycle wins the next same-word conflict, and the other port is held instead. No port is held for two cycles in a row.
- R8: Data phases on different words, or two reads of one word, complete with zero wait states on both ports.
- R9: Every returned read value equals one whole value that the word has held, never a blend of bytes from two writes.
- R10: Each beat of a four-beat incrementing burst is arbitrated on its own, and the other port may complete reads of the burst's words between beats, seeing each beat's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Per-port address-phase request |
| addr_i | input | 2 x (log2(WORDS)+2) | Per-port byte address |
| write_i | input | 2 | Per-port direction, 1 = write |
| size_i | input | 2 x 3 | Per-port transfer size code |
| wdata_i | input | 2 x 32 | Per-port write data, data phase |
| wstrb_i | input | 2 x 4 | Per-port byte strobes, data phase |
| ready_o | output | 2 | Per-port data-phase completion |
| rdata_o | output | 2 x 32 | Per-port read word, valid when ready is high |

## Verification
The bench aims at the same-word collision cases: a write on one port against a read on the other in the same cycle, two writes to one word, and back-to-back collisions where the held port must win next. A design with the wrong priority would return the old word to port 1 or hold a port twice, and a design without the conflict check would let a reader see a word mid-update. Strobe patterns with gaps, such as bytes 0 and 3 only, and byte and half-word sizes at every lane offset show whether lane masking and strobe merging touch the wrong bytes. Random traffic confined to four words makes collisions frequent. Every returned word is matched against the history of whole values of that word, which exposes any blend of old and new bytes.

// File: rtl/atom_mem_pkg.sv
package atom_mem_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'b000,
        SZ_HALF = 3'b001,
        SZ_WORD = 3'b010
    } xfer_size_e;

    // Byte lanes a transfer of a given size may touch at a given offset.
    function automatic logic [LANES-1:0] lane_mask(input logic [2:0] sz,
                                                   input logic [1:0] lo);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << lo;
            SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/atom_port_stage.sv
module atom_port_stage
    import atom_mem_pkg::*;
#(
    parameter int WAW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [WAW+1:0]   addr_i,
    input  logic             write_i,
    input  logic [2:0]       size_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [WAW-1:0]   word_o,
    output logic             wr_o,
    output logic [LANES-1:0] lanes_o
);

    typedef struct packed {
        logic             valid;
        logic [WAW-1:0]   word;
        logic             wr;
        logic [LANES-1:0] lanes;
    } dphase_t;

    dphase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ready_i) begin
            st_d.valid = req_i;
            st_d.word  = addr_i[WAW+1:2];
            st_d.wr    = write_i;
            st_d.lanes = lane_mask(size_i, addr_i[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;
    assign wr_o    = st_q.wr;
    assign lanes_o = st_q.lanes;

endmodule

// File: rtl/atom_conflict_arb.sv
module atom_conflict_arb #(
    parameter int WAW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          valid_i,
    input  logic [1:0][WAW-1:0] word_i,
    input  logic [1:0]          wr_i,
    output logic [1:0]          stall_o
);

    typedef struct packed {
        logic favour_p1;
    } arb_t;

    arb_t arb_d, arb_q;
    logic clash;

    always_comb begin
        clash = valid_i[0] && valid_i[1] && (word_i[0] == word_i[1])
                && (wr_i[0] || wr_i[1]);
        stall_o[0] = clash && arb_q.favour_p1;
        stall_o[1] = clash && !arb_q.favour_p1;
        // The loser of a clash is favoured on the following cycle.
        arb_d.favour_p1 = clash ? !arb_q.favour_p1 : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

endmodule

// File: rtl/atom_word_store.sv
module atom_word_store
    import atom_mem_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int WAW   = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    we_i,
    input  logic [1:0][WAW-1:0]           word_i,
    input  logic [1:0][LANES-1:0]         be_i,
    input  logic [1:0][DATA_W-1:0]        wdata_i,
    output logic [1:0][DATA_W-1:0]        rdata_o
);

    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < LANES; l++) begin
                if (we_i[p] && be_i[p][l])
                    mem_d[word_i[p]][l*8 +: 8] = wdata_i[p][l*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        assign rdata_o[p] = mem_q[word_i[p]];
    end

endmodule

// File: rtl/atom_word_mem.sv
module atom_word_mem
    import atom_mem_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int WAW  = $clog2(WORDS),
    localparam int AW   = WAW + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             req_i,
    input  logic [1:0][AW-1:0]     addr_i,
    input  logic [1:0]             write_i,
    input  logic [1:0][2:0]        size_i,
    input  logic [1:0][31:0]       wdata_i,
    input  logic [1:0][3:0]        wstrb_i,
    output logic [1:0]             ready_o,
    output logic [1:0][31:0]       rdata_o
);

    logic [1:0]             dph_valid;
    logic [1:0][WAW-1:0]    dph_word;
    logic [1:0]             dph_wr;
    logic [1:0][LANES-1:0]  dph_lanes;
    logic [1:0]             stall;
    logic [1:0]             commit_we;
    logic [1:0][LANES-1:0]  commit_be;

    for (genvar p = 0; p < 2; p++) begin : g_port
        atom_port_stage #(.WAW(WAW)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_i[p]),
            .addr_i  (addr_i[p]),
            .write_i (write_i[p]),
            .size_i  (size_i[p]),
            .ready_i (ready_o[p]),
            .valid_o (dph_valid[p]),
            .word_o  (dph_word[p]),
            .wr_o    (dph_wr[p]),
            .lanes_o (dph_lanes[p])
        );
        assign ready_o[p]   = !stall[p];
        assign commit_we[p] = dph_valid[p] && dph_wr[p] && !stall[p];
        assign commit_be[p] = dph_lanes[p] & wstrb_i[p];
    end

    atom_conflict_arb #(.WAW(WAW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (dph_valid),
        .word_i  (dph_word),
        .wr_i    (dph_wr),
        .stall_o (stall)
    );

    atom_word_store #(.WORDS(WORDS), .WAW(WAW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (commit_we),
        .word_i  (dph_word),
        .be_i    (commit_be),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

endmodule

// File: rtl/atom_word_mem_chk.sv
module atom_word_mem_chk #(
    parameter int WAW = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          ready_o,
    input logic [1:0]          dph_valid,
    input logic [1:0][WAW-1:0] dph_word,
    input logic [1:0]          dph_wr
);

    logic same_word_clash;
    assign same_word_clash = dph_valid[0] && dph_valid[1]
                             && (dph_word[0] == dph_word[1])
                             && (dph_wr[0] || dph_wr[1]);

    // R6
    p0_wins_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_word_clash && $past(ready_o[0]) && $past(ready_o[1])
        |-> ready_o[0] && !ready_o[1]);

    // R7
    held_p1_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_word_clash && !$past(ready_o[1]) |-> ready_o[1] && !ready_o[0]);

    // R7
    held_p0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        same_word_clash && !$past(ready_o[0]) |-> ready_o[0] && !ready_o[1]);

    // R6
    p0_single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o[0] |=> ready_o[0]);

    // R6
    p1_single_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o[1] |=> ready_o[1]);

    // R5
    p0_hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o[0] |=> dph_valid[0] && $stable(dph_word[0]));

    // R5
    p1_hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o[1] |=> dph_valid[1] && $stable(dph_word[1]));

    // R8
    no_clash_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dph_valid[0] && dph_valid[1]
        && ((dph_word[0] != dph_word[1]) || (!dph_wr[0] && !dph_wr[1]))
        |-> ready_o[0] && ready_o[1]);

endmodule

bind atom_word_mem atom_word_mem_chk #(.WAW(WAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_o   (ready_o),
    .dph_valid (dph_valid),
    .dph_word  (dph_word),
    .dph_wr    (dph_wr)
);

// File: tb/atom_word_mem_tb.sv
module atom_word_mem_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 16;
    localparam int AW         = $clog2(WORDS) + 2;

    typedef struct {
        logic          req;
        logic [AW-1:0] addr;
        logic          wr;
        logic [2:0]    size;
        logic [31:0]   wdata;
        logic [3:0]    wstrb;
    } op_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_i = '0;
    logic [1:0][AW-1:0]   addr_i = '0;
    logic [1:0]           write_i = '0;
    logic [1:0][2:0]      size_i = '0;
    logic [1:0][31:0]     wdata_i = '0;
    logic [1:0][3:0]      wstrb_i = '0;
    logic [1:0]           ready_o;
    logic [1:0][31:0]     rdata_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    op_t         opq [2][$];
    logic [31:0] rlog [2][$];
    logic [31:0] hist [WORDS][$];
    logic [31:0] mem_m [WORDS];
    bit          pend_v [2];
    op_t         pend   [2];
    bit          waited [2];
    bit          rand_mode = 0;

    atom_word_mem #(.WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .write_i(write_i), .size_i(size_i), .wdata_i(wdata_i),
        .wstrb_i(wstrb_i), .ready_o(ready_o), .rdata_o(rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes_of(input logic [2:0] sz, input logic [1:0] lo);
        if (sz == 3'b000) return 4'(1 << lo);
        if (sz == 3'b001) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic op_t mk(input logic [AW-1:0] a, input logic w,
                               input logic [2:0] s, input logic [31:0] d,
                               input logic [3:0] st);
        op_t o;
        o.req = 1'b1; o.addr = a; o.wr = w; o.size = s; o.wdata = d; o.wstrb = st;
        return o;
    endfunction

    function automatic op_t rnd_op();
        op_t o;
        o.req   = ($urandom_range(3) != 0);
        o.addr  = AW'($urandom_range(15));
        o.wr    = $urandom_range(1) == 1;
        o.size  = 3'($urandom_range(2));
        o.wdata = $urandom;
        o.wstrb = 4'($urandom);
        return o;
    endfunction

    // One clock of model and stimulus, run at the falling edge.
    task automatic step();
        bit clash;
        bit exp_rdy [2];
        int w;
        bit seen;
        logic [31:0] nv;
        op_t o;
        @(negedge clk);
        clash = pend_v[0] && pend_v[1]
                && (pend[0].addr[AW-1:2] == pend[1].addr[AW-1:2])
                && (pend[0].wr || pend[1].wr);
        exp_rdy[0] = !(clash && waited[1]);
        exp_rdy[1] = !(clash && !waited[1]);
        for (int p = 0; p < 2; p++) begin
            if (ready_o[p] != exp_rdy[p])
                check(0, clash ? ((waited[0] || waited[1]) ? "R7 held port priority"
                                                           : "R6 port 0 first")
                               : "R8 zero wait", 32'(ready_o[p]), 32'(exp_rdy[p]));
            else
                n_tests++;
            if (pend_v[p] && exp_rdy[p] && !pend[p].wr) begin
                w = int'(pend[p].addr[AW-1:2]);
                check(rdata_o[p] == mem_m[w],
                      pend[p].size == 3'b000 ? "R4 byte read word" : "R5 read data phase",
                      rdata_o[p], mem_m[w]);
                seen = 0;
                foreach (hist[w][k]) if (hist[w][k] == rdata_o[p]) seen = 1;
                check(seen, "R9 whole-word snapshot", rdata_o[p], mem_m[w]);
                rlog[p].push_back(rdata_o[p]);
            end
        end
        // Data phase inputs for the transfer now in its data phase.
        for (int p = 0; p < 2; p++) begin
            wdata_i[p] = pend[p].wdata;
            wstrb_i[p] = pend[p].wstrb;
        end
        // Commit writes that complete on the coming edge.
        for (int p = 0; p < 2; p++) begin
            if (pend_v[p] && exp_rdy[p] && pend[p].wr) begin
                w  = int'(pend[p].addr[AW-1:2]);
                nv = mem_m[w];
                for (int l = 0; l < 4; l++)
                    if (lanes_of(pend[p].size, pend[p].addr[1:0])[l] && pend[p].wstrb[l])
                        nv[l*8 +: 8] = pend[p].wdata[l*8 +: 8];
                mem_m[w] = nv;
                hist[w].push_back(nv);
            end
        end
        // New address phases.
        for (int p = 0; p < 2; p++) begin
            waited[p] = !exp_rdy[p];
            if (exp_rdy[p]) begin
                if (opq[p].size() > 0) o = opq[p].pop_front();
                else if (rand_mode)    o = rnd_op();
                else begin o = rnd_op(); o.req = 1'b0; end
                req_i[p]   = o.req;
                addr_i[p]  = o.addr;
                write_i[p] = o.wr;
                size_i[p]  = o.size;
                pend_v[p]  = o.req;
                pend[p]    = o;
            end
        end
    endtask

    task automatic drain();
        while (opq[0].size() > 0 || opq[1].size() > 0 || pend_v[0] || pend_v[1])
            step();
        step();
    endtask

    task automatic clear_logs();
        rlog[0].delete();
        rlog[1].delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int w = 0; w < WORDS; w++) begin
            mem_m[w] = '0;
            hist[w].push_back(32'h0);
        end
        for (int p = 0; p < 2; p++) begin
            pend_v[p] = 0; waited[p] = 0; pend[p] = mk('0, 0, 0, 0, 0);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready_o == 2'b11, "R1 ready after reset", 32'(ready_o), 32'h3);
        check(rdata_o[0] == 32'h0, "R1 zero contents", rdata_o[0], 32'h0);

        // R2 gapped strobe merge
        clear_logs();
        opq[0].push_back(mk(6'h04, 1, 3'b010, 32'hAABBCCDD, 4'b1111));
        opq[0].push_back(mk(6'h04, 1, 3'b010, 32'h11223344, 4'b1001));
        opq[0].push_back(mk(6'h04, 0, 3'b010, 32'h0, 4'b0));
        drain();
        check(rlog[0].size() == 1 && rlog[0][0] == 32'h11BBCC44,
              "R2 strobes 0 and 3", rlog[0].size() > 0 ? rlog[0][0] : 32'hX, 32'h11BBCC44);

        // R3 byte and half lanes
        clear_logs();
        opq[0].push_back(mk(6'h0A, 1, 3'b000, 32'hFFFFFFFF, 4'b1111));
        opq[0].push_back(mk(6'h0E, 1, 3'b001, 32'h12345678, 4'b1111));
        opq[0].push_back(mk(6'h11, 1, 3'b001, 32'h9ABCDEF0, 4'b1111));
        opq[0].push_back(mk(6'h08, 0, 3'b000, 32'h0, 4'b0));
        opq[0].push_back(mk(6'h0C, 0, 3'b001, 32'h0, 4'b0));
        opq[0].push_back(mk(6'h10, 0, 3'b010, 32'h0, 4'b0));
        drain();
        check(rlog[0].size() == 3 && rlog[0][0] == 32'h00FF0000,
              "R3 byte lane 2", rlog[0].size() > 0 ? rlog[0][0] : 32'hX, 32'h00FF0000);
        check(rlog[0].size() == 3 && rlog[0][1] == 32'h12340000,
              "R3 upper half", rlog[0].size() > 1 ? rlog[0][1] : 32'hX, 32'h12340000);
        check(rlog[0].size() == 3 && rlog[0][2] == 32'h0000DEF0,
              "R3 lower half", rlog[0].size() > 2 ? rlog[0][2] : 32'hX, 32'h0000DEF0);

        // R6 write on port 0 against read on port 1, then the reverse
        clear_logs();
        opq[0].push_back(mk(6'h14, 1, 3'b010, 32'hCAFEF00D, 4'b1111));
        opq[1].push_back(mk(6'h14, 0, 3'b000, 32'h0, 4'b0));
        drain();
        check(rlog[1].size() == 1 && rlog[1][0] == 32'hCAFEF00D,
              "R6 held reader sees new word", rlog[1].size() > 0 ? rlog[1][0] : 32'hX, 32'hCAFEF00D);
        clear_logs();
        opq[0].push_back(mk(6'h14, 0, 3'b010, 32'h0, 4'b0));
        opq[0].push_back(mk(6'h14, 0, 3'b010, 32'h0, 4'b0));
        opq[1].push_back(mk(6'h14, 1, 3'b010, 32'h5A5A5A5A, 4'b1111));
        drain();
        check(rlog[0].size() == 2 && rlog[0][0] == 32'hCAFEF00D,
              "R6 port 0 reads old word first", rlog[0].size() > 0 ? rlog[0][0] : 32'hX, 32'hCAFEF00D);

        // R7 held writer wins the next clash
        clear_logs();
        opq[0].push_back(mk(6'h18, 1, 3'b010, 32'hA0A0A0A0, 4'b1111));
        opq[0].push_back(mk(6'h18, 0, 3'b010, 32'h0, 4'b0));
        opq[1].push_back(mk(6'h18, 1, 3'b010, 32'hB1B1B1B1, 4'b1111));
        drain();
        check(rlog[0].size() == 1 && rlog[0][0] == 32'hB1B1B1B1,
              "R7 held port 1 writes before port 0 reads",
              rlog[0].size() > 0 ? rlog[0][0] : 32'hX, 32'hB1B1B1B1);

        // R8 simultaneous reads, same word and different words
        clear_logs();
        opq[0].push_back(mk(6'h18, 0, 3'b010, 32'h0, 4'b0));
        opq[1].push_back(mk(6'h18, 0, 3'b010, 32'h0, 4'b0));
        opq[0].push_back(mk(6'h04, 0, 3'b010, 32'h0, 4'b0));
        opq[1].push_back(mk(6'h14, 0, 3'b010, 32'h0, 4'b0));
        drain();
        check(rlog[1].size() == 2 && rlog[1][1] == 32'h5A5A5A5A,
              "R8 parallel reads", rlog[1].size() > 1 ? rlog[1][1] : 32'hX, 32'h5A5A5A5A);

        // R10 burst on port 0 interleaved with reads on port 1
        clear_logs();
        for (int b = 0; b < 4; b++) begin
            opq[0].push_back(mk(AW'(32 + 4*b), 1, 3'b010, 32'hB0000000 + 32'(b), 4'b1111));
            opq[1].push_back(mk(AW'(32 + 4*b), 0, 3'b010, 32'h0, 4'b0));
        end
        drain();
        for (int b = 0; b < 4; b++)
            check(rlog[1].size() == 4 && rlog[1][b] == 32'hB0000000 + 32'(b),
                  "R10 per-beat interleave",
                  rlog[1].size() > b ? rlog[1][b] : 32'hX, 32'hB0000000 + 32'(b));

        // Random concurrent traffic on four words (R2 R4 R5 R6 R7 R8 R9)
        rand_mode = 1;
        repeat (3000) step();
        rand_mode = 0;
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule